// File: doc/BRIEF.md
# Queue Command Sequencer

This block walks one storage command at a time from a host submission queue to a local consumer and back to a host completion queue. The host writes a new tail value into a doorbell register over a write-only AXI4-Lite slave. While the local head pointer differs from that tail, the block fetches the 64-byte entry at the head slot over a one-beat memory-read port. If the entry asks for it, the block makes one extra fetch for a pointer list. It then checks the opcode against the set the queue supports.

A supported entry is offered to the consumer. The consumer answers with a work request that gives the transfer direction, address and length. The block routes one DMA descriptor to the card-to-host port for a write-type request, or to the host-to-card port for a read-type request, and waits for the DMA done pulse. It then offers a work completion and waits for the consumer's completion request, which carries the status. Only after that does it write a 16-byte completion entry to the host and pulse the interrupt.

An unsupported opcode skips the consumer entirely and is completed straight away with an error status. The `ADMIN_Q` parameter selects the opcode set for a management queue instead of a data queue.

Top module: `sq_cmd_sequencer`

## Requirements
- R1: A write handshake at byte offset `DB_OFFSET` loads the low `log2(DEPTH)` bits of the write data as the new submission tail. A write to any other offset changes nothing: with head equal to tail, no fetch follows it. Every write gets one response, with `sBResp` = 0.
- R2: While head differs from tail, the block requests an entry at `SQ_BASE + 64*head`.
- R3: When bit 15 of the fetched entry is set, one extra fetch is issued at the 64-bit address in entry bits [255:192]. This happens before anything is offered to the consumer.
- R4: An entry with a supported opcode (entry bits [7:0]; data queue: 0x00, 0x01, 0x02; management queue: 0x02, 0x06, 0x09, 0x0A) is offered on `cmdData` unchanged. It is held until `cmdReady`.
- R5: After the work request, a write-type request (`wrIsWrite`=1) raises only `c2hDescValid`, and a read-type request raises only `h2cDescValid`. The descriptor carries the request's address and length.
- R6: After `dmaDone`, `wcValid` is held until `wcReady`. No completion write is issued before the consumer's completion request has been accepted.
- R7: The completion entry goes to `CQ_BASE + 16*cqTail`. Its layout is: [127:113] status, [112] phase, [111:96] command identifier (entry bits [31:16]), [95:80] `SQ_ID`, [79:64] the submission head after the fetch, and [63:0] zero.
- R8: The completion tail advances modulo `DEPTH` on each completion write. The phase starts at 1 and inverts every time the tail wraps to 0.
- R9: An unsupported opcode is never offered to the consumer. Its completion is written directly with status 0x0001.
- R10: `irqPulse` is high for exactly one cycle, the cycle right after the completion write handshake.
- R11: Head starts at 0 after reset and advances modulo `DEPTH` on each entry fetch. Fetching stops when head reaches tail.
- R12: Every valid this block drives (fetch, command, descriptor, work completion, completion write) holds high, with a stable payload, until its ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sAwValid | input | 1 | Slave write-address valid |
| sAwReady | output | 1 | Slave write-address ready |
| sAwAddr | input | AXI_ADDR_W | Slave write byte offset |
| sWValid | input | 1 | Slave write-data valid |
| sWReady | output | 1 | Slave write-data ready |
| sWData | input | AXI_DATA_W | Slave write data |
| sBValid | output | 1 | Write response valid |
| sBReady | input | 1 | Write response ready |
| sBResp | output | 2 | Write response code, always OKAY |
| fetchReqValid | output | 1 | Entry/list read request valid |
| fetchReqReady | input | 1 | Read request accepted |
| fetchReqAddr | output | ADDR_W | Read request host address |
| fetchRespValid | input | 1 | Read response valid |
| fetchRespData | input | 512 | Read response, one 64-byte entry |
| cmdValid | output | 1 | Command offered to consumer |
| cmdReady | input | 1 | Consumer accepts command |
| cmdData | output | 512 | Command entry |
| wrValid | input | 1 | Work request valid |
| wrReady | output | 1 | Work request accepted |
| wrIsWrite | input | 1 | 1: card-to-host, 0: host-to-card |
| wrAddr | input | ADDR_W | Work request buffer address |
| wrLen | input | LEN_W | Work request byte length |
| c2hDescValid | output | 1 | Card-to-host descriptor valid |
| c2hDescReady | input | 1 | Card-to-host descriptor ready |
| h2cDescValid | output | 1 | Host-to-card descriptor valid |
| h2cDescReady | input | 1 | Host-to-card descriptor ready |
| descAddr | output | ADDR_W | Descriptor address (shared) |
| descLen | output | LEN_W | Descriptor length (shared) |
| dmaDone | input | 1 | Transfer finished pulse |
| wcValid | output | 1 | Work completion to consumer |
| wcReady | input | 1 | Consumer accepts work completion |
| crValid | input | 1 | Completion request from consumer |
| crReady | output | 1 | Completion request accepted |
| crStatus | input | 15 | Status for the completion entry |
| cplValid | output | 1 | Completion write valid |
| cplReady | input | 1 | Completion write accepted |
| cplAddr | output | ADDR_W | Completion entry host address |
| cplData | output | 128 | Completion entry |
| irqPulse | output | 1 | Host interrupt pulse |

## Verification
The embedded assertions check on every cycle that each outgoing valid holds until its ready. They also check that the interrupt is a lone pulse that follows a completion handshake, that head only ever steps by one slot modulo the depth, and that the phase flips only when the completion tail lands on zero. The bench scenarios are needed for the rest. They show the exact fetch and list addresses, the direction routing of descriptors, and that nothing is posted before the consumer's request. They also show that a bad opcode bypasses the consumer, that the completion fields and phase are correct across a queue wrap, and that fetching stops at the tail and ignores writes to other offsets.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int ENTRY_W  = 512;
  localparam int CPL_W    = 128;
  localparam int STATUS_W = 15;
  localparam logic [STATUS_W-1:0] BAD_OPCODE_STATUS = 15'h0001;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_CHECK, S_LIST, S_LWAIT, S_DECIDE, S_PUSH,
    S_WORK, S_DESC, S_DMA, S_WCPL, S_CREQ, S_CPL, S_IRQ
  } seqState_t;

  typedef struct packed {
    logic loadEntry;
    logic bumpHead;
    logic useList;
    logic loadWork;
    logic setBad;
    logic loadStatus;
    logic bumpCq;
  } seqStrobe_t;
endpackage

// File: rtl/cmdseq_datapath.sv
module cmdseq_datapath
  import cmdseq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AXI_ADDR_W = 12,
  parameter int AXI_DATA_W = 32,
  parameter int ADDR_W = 64,
  parameter int LEN_W = 32,
  parameter logic [AXI_ADDR_W-1:0] DB_OFFSET = 'h008,
  parameter logic [ADDR_W-1:0] SQ_BASE = 'h1_0000_0000,
  parameter logic [ADDR_W-1:0] CQ_BASE = 'h2_0000_0000,
  parameter int SQ_ID = 1,
  parameter bit ADMIN_Q = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  seqStrobe_t stb,
  input  logic sAwValid,
  output logic sAwReady,
  input  logic [AXI_ADDR_W-1:0] sAwAddr,
  input  logic sWValid,
  output logic sWReady,
  input  logic [AXI_DATA_W-1:0] sWData,
  output logic sBValid,
  input  logic sBReady,
  input  logic [ENTRY_W-1:0] fetchRespData,
  input  logic wrIsWrite,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LEN_W-1:0] wrLen,
  input  logic [STATUS_W-1:0] crStatus,
  output logic [ADDR_W-1:0] fetchReqAddr,
  output logic [ENTRY_W-1:0] cmdData,
  output logic descIsWrite,
  output logic [ADDR_W-1:0] descAddr,
  output logic [LEN_W-1:0] descLen,
  output logic [ADDR_W-1:0] cplAddr,
  output logic [CPL_W-1:0] cplData,
  output logic queueBusy,
  output logic needList,
  output logic opcodeOk
);
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] tail, head, cqTail;
  logic phase;
  logic [ENTRY_W-1:0] entry;
  logic [STATUS_W-1:0] status;
  logic bValidQ;
  logic dbAccept;
  logic [7:0] opcode;
  logic unusedWData;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign unusedWData = ^sWData;
  assign sAwReady = !bValidQ;
  assign sWReady  = !bValidQ;
  assign sBValid  = bValidQ;
  assign dbAccept = sAwValid && sWValid && !bValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValidQ <= 1'b0;
      tail    <= '0;
    end else begin
      if (dbAccept) begin
        bValidQ <= 1'b1;
        if (sAwAddr == DB_OFFSET) tail <= sWData[PTR_W-1:0];
      end else if (sBReady) begin
        bValidQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head        <= '0;
      cqTail      <= '0;
      phase       <= 1'b1;
      entry       <= '0;
      status      <= '0;
      descIsWrite <= 1'b0;
      descAddr    <= '0;
      descLen     <= '0;
    end else begin
      if (stb.loadEntry) entry <= fetchRespData;
      if (stb.bumpHead) head <= stepPtr(head);
      if (stb.loadWork) begin
        descIsWrite <= wrIsWrite;
        descAddr    <= wrAddr;
        descLen     <= wrLen;
      end
      if (stb.setBad) status <= BAD_OPCODE_STATUS;
      else if (stb.loadStatus) status <= crStatus;
      if (stb.bumpCq) begin
        cqTail <= stepPtr(cqTail);
        if (cqTail == LAST) phase <= !phase;
      end
    end
  end

  assign opcode = entry[7:0];
  generate
    if (ADMIN_Q) begin : g_mgmtSet
      assign opcodeOk = (opcode == 8'h02) || (opcode == 8'h06) ||
                        (opcode == 8'h09) || (opcode == 8'h0A);
    end else begin : g_dataSet
      assign opcodeOk = (opcode == 8'h00) || (opcode == 8'h01) || (opcode == 8'h02);
    end
  endgenerate

  assign queueBusy    = (head != tail);
  assign needList     = entry[15];
  assign cmdData      = entry;
  assign fetchReqAddr = stb.useList ? entry[255:192]
                                    : SQ_BASE + (ADDR_W'(head) << 6);
  assign cplAddr      = CQ_BASE + (ADDR_W'(cqTail) << 4);
  assign cplData      = {status, phase, entry[31:16], 16'(SQ_ID), 16'(head), 64'h0};

  assert_head_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (head != $past(head)) |-> (head == stepPtr($past(head))));
  assert_phase_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase)) |-> (cqTail == '0));
  assert_resp_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (bValidQ && !sBReady) |=> bValidQ);
endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
  import cmdseq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic queueBusy,
  input  logic needList,
  input  logic opcodeOk,
  input  logic fetchReqReady,
  input  logic fetchRespValid,
  input  logic cmdReady,
  input  logic wrValid,
  input  logic descReady,
  input  logic dmaDone,
  input  logic wcReady,
  input  logic crValid,
  input  logic cplReady,
  output logic fetchReqValid,
  output logic cmdValid,
  output logic wrReady,
  output logic descValid,
  output logic wcValid,
  output logic crReady,
  output logic cplValid,
  output logic irqPulse,
  output seqStrobe_t stb
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb = '0;
    fetchReqValid = 1'b0;
    cmdValid = 1'b0;
    wrReady = 1'b0;
    descValid = 1'b0;
    wcValid = 1'b0;
    crReady = 1'b0;
    cplValid = 1'b0;
    irqPulse = 1'b0;
    case (state)
      S_IDLE:   if (queueBusy) nextState = S_FETCH;
      S_FETCH: begin
        fetchReqValid = 1'b1;
        if (fetchReqReady) nextState = S_FWAIT;
      end
      S_FWAIT:
        if (fetchRespValid) begin
          stb.loadEntry = 1'b1;
          stb.bumpHead  = 1'b1;
          nextState = S_CHECK;
        end
      S_CHECK:  nextState = needList ? S_LIST : S_DECIDE;
      S_LIST: begin
        fetchReqValid = 1'b1;
        stb.useList = 1'b1;
        if (fetchReqReady) nextState = S_LWAIT;
      end
      S_LWAIT:  if (fetchRespValid) nextState = S_DECIDE;
      S_DECIDE:
        if (opcodeOk) nextState = S_PUSH;
        else begin
          stb.setBad = 1'b1;
          nextState = S_CPL;
        end
      S_PUSH: begin
        cmdValid = 1'b1;
        if (cmdReady) nextState = S_WORK;
      end
      S_WORK: begin
        wrReady = 1'b1;
        if (wrValid) begin
          stb.loadWork = 1'b1;
          nextState = S_DESC;
        end
      end
      S_DESC: begin
        descValid = 1'b1;
        if (descReady) nextState = S_DMA;
      end
      S_DMA:    if (dmaDone) nextState = S_WCPL;
      S_WCPL: begin
        wcValid = 1'b1;
        if (wcReady) nextState = S_CREQ;
      end
      S_CREQ: begin
        crReady = 1'b1;
        if (crValid) begin
          stb.loadStatus = 1'b1;
          nextState = S_CPL;
        end
      end
      S_CPL: begin
        cplValid = 1'b1;
        if (cplReady) begin
          stb.bumpCq = 1'b1;
          nextState = S_IRQ;
        end
      end
      S_IRQ: begin
        irqPulse = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assert_fetch_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReqValid && !fetchReqReady) |=> fetchReqValid);
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid);
  assert_wc_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wcValid && !wcReady) |=> wcValid);
  assert_cpl_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && !cplReady) |=> cplValid);
  assert_irq_after_cpl_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(cplValid && cplReady));
  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
endmodule

// File: rtl/sq_cmd_sequencer.sv
module sq_cmd_sequencer
  import cmdseq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AXI_ADDR_W = 12,
  parameter int AXI_DATA_W = 32,
  parameter int ADDR_W = 64,
  parameter int LEN_W = 32,
  parameter logic [AXI_ADDR_W-1:0] DB_OFFSET = 'h008,
  parameter logic [ADDR_W-1:0] SQ_BASE = 'h1_0000_0000,
  parameter logic [ADDR_W-1:0] CQ_BASE = 'h2_0000_0000,
  parameter int SQ_ID = 1,
  parameter bit ADMIN_Q = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic sAwValid,
  output logic sAwReady,
  input  logic [AXI_ADDR_W-1:0] sAwAddr,
  input  logic sWValid,
  output logic sWReady,
  input  logic [AXI_DATA_W-1:0] sWData,
  output logic sBValid,
  input  logic sBReady,
  output logic [1:0] sBResp,
  output logic fetchReqValid,
  input  logic fetchReqReady,
  output logic [ADDR_W-1:0] fetchReqAddr,
  input  logic fetchRespValid,
  input  logic [511:0] fetchRespData,
  output logic cmdValid,
  input  logic cmdReady,
  output logic [511:0] cmdData,
  input  logic wrValid,
  output logic wrReady,
  input  logic wrIsWrite,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LEN_W-1:0] wrLen,
  output logic c2hDescValid,
  input  logic c2hDescReady,
  output logic h2cDescValid,
  input  logic h2cDescReady,
  output logic [ADDR_W-1:0] descAddr,
  output logic [LEN_W-1:0] descLen,
  input  logic dmaDone,
  output logic wcValid,
  input  logic wcReady,
  input  logic crValid,
  output logic crReady,
  input  logic [14:0] crStatus,
  output logic cplValid,
  input  logic cplReady,
  output logic [ADDR_W-1:0] cplAddr,
  output logic [127:0] cplData,
  output logic irqPulse
);
  seqStrobe_t stb;
  logic queueBusy, needList, opcodeOk, descValid, descIsWrite, descReady;

  assign sBResp       = 2'b00;
  assign c2hDescValid = descValid && descIsWrite;
  assign h2cDescValid = descValid && !descIsWrite;
  assign descReady    = descIsWrite ? c2hDescReady : h2cDescReady;

  cmdseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .queueBusy(queueBusy), .needList(needList),
    .opcodeOk(opcodeOk), .fetchReqReady(fetchReqReady),
    .fetchRespValid(fetchRespValid), .cmdReady(cmdReady), .wrValid(wrValid),
    .descReady(descReady), .dmaDone(dmaDone), .wcReady(wcReady),
    .crValid(crValid), .cplReady(cplReady), .fetchReqValid(fetchReqValid),
    .cmdValid(cmdValid), .wrReady(wrReady), .descValid(descValid),
    .wcValid(wcValid), .crReady(crReady), .cplValid(cplValid),
    .irqPulse(irqPulse), .stb(stb)
  );

  cmdseq_datapath #(
    .DEPTH(DEPTH), .AXI_ADDR_W(AXI_ADDR_W), .AXI_DATA_W(AXI_DATA_W),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DB_OFFSET(DB_OFFSET),
    .SQ_BASE(SQ_BASE), .CQ_BASE(CQ_BASE), .SQ_ID(SQ_ID), .ADMIN_Q(ADMIN_Q)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sAwValid(sAwValid),
    .sAwReady(sAwReady), .sAwAddr(sAwAddr), .sWValid(sWValid),
    .sWReady(sWReady), .sWData(sWData), .sBValid(sBValid), .sBReady(sBReady),
    .fetchRespData(fetchRespData), .wrIsWrite(wrIsWrite), .wrAddr(wrAddr),
    .wrLen(wrLen), .crStatus(crStatus), .fetchReqAddr(fetchReqAddr),
    .cmdData(cmdData), .descIsWrite(descIsWrite), .descAddr(descAddr),
    .descLen(descLen), .cplAddr(cplAddr), .cplData(cplData),
    .queueBusy(queueBusy), .needList(needList), .opcodeOk(opcodeOk)
  );

  assert_desc_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((c2hDescValid && !c2hDescReady) || (h2cDescValid && !h2cDescReady))
      |=> ((c2hDescValid || h2cDescValid) && $stable(descAddr) && $stable(descLen)));
  assert_fetch_addr_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReqValid && !fetchReqReady) |=> $stable(fetchReqAddr));
  assert_cpl_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && !cplReady) |=> ($stable(cplData) && $stable(cplAddr)));
endmodule

// File: tb/tb_sq_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_sq_cmd_sequencer;
  localparam int DEPTH = 4;
  localparam logic [63:0] SQB = 64'h1_0000_0000;
  localparam logic [63:0] CQB = 64'h2_0000_0000;
  localparam logic [11:0] DBO = 12'h008;

  logic clk = 1'b0, rstN = 1'b0;
  logic sAwValid = 0, sWValid = 0, sBReady = 0;
  logic [11:0] sAwAddr = '0;
  logic [31:0] sWData = '0;
  logic sAwReady, sWReady, sBValid;
  logic [1:0] sBResp;
  logic fetchReqValid, fetchReqReady = 1'b1, fetchRespValid = 0;
  logic [63:0] fetchReqAddr;
  logic [511:0] fetchRespData = '0, cmdData;
  logic cmdValid, cmdReady = 0, wrValid = 0, wrReady, wrIsWrite = 0;
  logic [63:0] wrAddr = '0, descAddr, cplAddr;
  logic [31:0] wrLen = '0, descLen;
  logic c2hDescValid, c2hDescReady = 0, h2cDescValid, h2cDescReady = 0;
  logic dmaDone = 0, wcValid, wcReady = 0, crValid = 0, crReady;
  logic [14:0] crStatus = '0;
  logic cplValid, cplReady = 0, irqPulse;
  logic [127:0] cplData;

  int checks = 0, fails = 0, cycles = 0;
  int expCq = 0;
  bit expPhase = 1'b1;
  bit cmdSeen = 1'b0;
  logic prevHs = 1'b0;
  logic [7:0] slotOp[DEPTH];
  bit slotList[DEPTH];
  logic [15:0] slotCid[DEPTH];

  always #2.5 clk = ~clk;

  sq_cmd_sequencer dut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] listAddrOf(input int s);
    return 64'h8000_0000 + 64'(s) * 64'h100;
  endfunction

  function automatic logic [511:0] entryOf(input int s);
    logic [511:0] e = {16{32'hC0DE_0000 | 32'(s)}};
    e[7:0] = slotOp[s];
    e[14:8] = '0;
    e[15] = slotList[s];
    e[31:16] = slotCid[s];
    e[255:192] = listAddrOf(s);
    return e;
  endfunction

  function automatic bit supported(input logic [7:0] op);
    return op == 8'h00 || op == 8'h01 || op == 8'h02;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    prevHs <= cplValid && cplReady;
    if (cmdValid) cmdSeen <= 1'b1;
  end

  // per-cycle reference: interrupt exactly one cycle after completion handshake
  always @(negedge clk) begin
    if (rstN && (irqPulse || prevHs))
      chk(irqPulse == prevHs, "R10", 128'(irqPulse), 128'(prevHs));
    if (rstN && c2hDescValid && h2cDescValid)
      chk(1'b0, "R5", 128'(2'b11), 128'(1));
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", 128'(cycles), 128'(0));
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic dbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sAwValid = 1; sWValid = 1; sAwAddr = a; sWData = d;
    while (!sAwReady) @(negedge clk);
    @(negedge clk);
    sAwValid = 0; sWValid = 0;
    chk(sBValid && sBResp == 2'b00, "R1", 128'({sBValid, sBResp}), 128'({1'b1, 2'b00}));
    sBReady = 1;
    @(negedge clk);
    sBReady = 0;
  endtask

  task automatic runCmd(input int slot, input bit isWr, input logic [14:0] crSt);
    logic [511:0] e;
    logic [14:0] expSt;
    logic [127:0] expCpl;
    bit good;
    e = entryOf(slot);
    good = supported(slotOp[slot]);
    cmdSeen = 1'b0;
    while (!fetchReqValid) @(negedge clk);
    chk(fetchReqAddr == SQB + 64'(slot) * 64, "R2", 128'(fetchReqAddr), 128'(SQB + 64'(slot) * 64));
    @(negedge clk);
    fetchRespValid = 1; fetchRespData = e;
    @(negedge clk);
    fetchRespValid = 0;
    if (slotList[slot]) begin
      while (!fetchReqValid) @(negedge clk);
      chk(fetchReqAddr == listAddrOf(slot), "R3", 128'(fetchReqAddr), 128'(listAddrOf(slot)));
      chk(!cmdSeen, "R3", 128'(cmdSeen), 128'(0));
      @(negedge clk);
      fetchRespValid = 1; fetchRespData = ~e;
      @(negedge clk);
      fetchRespValid = 0;
    end
    if (good) begin
      while (!cmdValid) @(negedge clk);
      chk(cmdData == e, "R4", cmdData[127:0], e[127:0]);
      cmdReady = 1;
      @(negedge clk);
      cmdReady = 0;
      while (!wrReady) @(negedge clk);
      wrValid = 1; wrIsWrite = isWr;
      wrAddr = 64'hD000_0000 + 64'(slot) * 64'h1000; wrLen = 32'(512 * (slot + 1));
      @(negedge clk);
      wrValid = 0;
      while (!(c2hDescValid || h2cDescValid)) @(negedge clk);
      chk(c2hDescValid == isWr && h2cDescValid == !isWr, "R5",
          128'({c2hDescValid, h2cDescValid}), 128'({isWr, !isWr}));
      chk(descAddr == wrAddr && descLen == wrLen, "R5",
          128'({descAddr, descLen}), 128'({wrAddr, wrLen}));
      if (isWr) c2hDescReady = 1; else h2cDescReady = 1;
      @(negedge clk);
      c2hDescReady = 0; h2cDescReady = 0;
      repeat (3) @(negedge clk);
      dmaDone = 1;
      @(negedge clk);
      dmaDone = 0;
      while (!wcValid) @(negedge clk);
      repeat (2) begin
        @(negedge clk);
        chk(wcValid && !cplValid, "R6", 128'({wcValid, cplValid}), 128'({1'b1, 1'b0}));
      end
      wcReady = 1;
      @(negedge clk);
      wcReady = 0;
      repeat (3) begin
        @(negedge clk);
        chk(!cplValid, "R6", 128'(cplValid), 128'(0));
      end
      while (!crReady) @(negedge clk);
      crValid = 1; crStatus = crSt;
      @(negedge clk);
      crValid = 0;
      expSt = crSt;
    end else begin
      expSt = 15'h0001;
    end
    while (!cplValid) @(negedge clk);
    if (!good) chk(!cmdSeen, "R9", 128'(cmdSeen), 128'(0));
    expCpl = {expSt, expPhase, slotCid[slot], 16'd1, 16'((slot + 1) % DEPTH), 64'h0};
    chk(cplData == expCpl, good ? "R7" : "R9", cplData, expCpl);
    chk(cplAddr == CQB + 64'(expCq) * 16, "R7", 128'(cplAddr), 128'(CQB + 64'(expCq) * 16));
    chk(cplData[112] == expPhase, "R8", 128'(cplData[112]), 128'(expPhase));
    @(negedge clk);
    chk(cplValid && cplData == expCpl, "R12", cplData, expCpl);
    cplReady = 1;
    @(negedge clk);
    cplReady = 0;
    chk(irqPulse, "R10", 128'(irqPulse), 128'(1));
    @(negedge clk);
    chk(!irqPulse, "R10", 128'(irqPulse), 128'(0));
    expCq = (expCq + 1) % DEPTH;
    if (expCq == 0) expPhase = !expPhase;
  endtask

  initial begin
    slotOp[0] = 8'h02; slotList[0] = 0; slotCid[0] = 16'h1111;
    slotOp[1] = 8'h01; slotList[1] = 1; slotCid[1] = 16'h2222;
    slotOp[2] = 8'h7F; slotList[2] = 0; slotCid[2] = 16'h3333;
    slotOp[3] = 8'h00; slotList[3] = 0; slotCid[3] = 16'h4444;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11: reset state, nothing requested
    chk(!fetchReqValid && !cmdValid && !cplValid && !irqPulse && !sBValid, "R11",
        128'({fetchReqValid, cmdValid, cplValid, irqPulse, sBValid}), 128'(0));
    // R1: write to another offset leaves the tail alone
    dbWrite(12'h010, 32'd1);
    repeat (6) begin
      @(negedge clk);
      chk(!fetchReqValid, "R1", 128'(fetchReqValid), 128'(0));
    end
    dbWrite(DBO, 32'd1);
    runCmd(0, 1'b1, 15'h0000);
    dbWrite(DBO, 32'd3);
    runCmd(1, 1'b0, 15'h0002);
    runCmd(2, 1'b0, 15'h0000);
    dbWrite(DBO, 32'd0);
    runCmd(3, 1'b1, 15'h0000);
    slotOp[0] = 8'h02; slotCid[0] = 16'h5555;
    dbWrite(DBO, 32'd1);
    runCmd(0, 1'b0, 15'h0004);
    // R11: head reached tail, no further fetch
    repeat (6) begin
      @(negedge clk);
      chk(!fetchReqValid, "R11", 128'(fetchReqValid), 128'(0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule